// File: doc/BRIEF.md
# Byte-Masked Burst Write Controller

This block turns one burst write request into a complete write transaction on an 8-bit double-data-rate memory bus with 16-bit memory words. A request gives a byte start address and a byte count, encoded as the count minus one. The bytes themselves arrive one by one on a valid/ready stream.

The controller pulls the select line low and sends a six-byte command/address header. It then runs a fixed latency gap of free-running clock edges and finishes with the data phase. During the data phase the strobe/mask line serves as a write mask for each edge. Because of that mask, a burst may start on an odd byte and may cover an odd number of bytes. Only the first and last words of a burst can be partly masked.

Each byte on the bus takes two system clocks. The bus clock toggles on one system clock and the data changes on the next, so the data is stable across every clock edge. The controller never samples the mask line, and it takes a new request only while it is idle.

States:
- `ST_IDLE`: waits for a request.
- `ST_CMD`: header, six edges.
- `ST_GAP`: latency, `2*LAT_PERIODS` edges.
- `ST_DATA`: one edge per byte slot.
- `ST_DONE`: releases the select line.

Every bus state alternates between two sub-steps: a setup step, which places the byte, and a strobe step, which toggles the clock.

Transitions:
- `ST_IDLE` to `ST_CMD` on an accepted request.
- `ST_CMD` to `ST_GAP` after the sixth edge.
- `ST_GAP` to `ST_DATA` after the last latency edge.
- `ST_DATA` to `ST_DONE` after the final data edge.
- `ST_DONE` to `ST_IDLE` unconditionally.

Top module: `hbus_mask_writer`

## Requirements
- R1: `req_ready` is high exactly when the block is idle. A request is taken only in that state. Requests presented while busy are ignored, and the transaction already running is not disturbed by them.
- R2: `bus_sel_n` goes low in the cycle after acceptance, with `bus_clk` low, and the first rising clock edge follows one system clock later. `bus_clk` is low whenever `bus_sel_n` is high.
- R3: The header is six bytes on the first six clock edges, most significant byte first, forming a 48-bit word with these fields:
  - bit 47 = 0 (write)
  - bit 46 = 0 (memory space)
  - bit 45 = 1 (linear burst)
  - bits 44:16 = word address bits 31:3
  - bits 15:3 = 0
  - bits 2:0 = word address bits 2:0
  
  The word address is the byte address shifted right by one.
- R4: Exactly `2*LAT_PERIODS` clock edges lie between the last header edge and the first data edge. The first data edge therefore comes at edge index `6+2*LAT_PERIODS`.
- R5: Without stalls, clock edge g occurs 2g+1 cycles after `bus_sel_n` falls. `bus_dq` never changes in a cycle in which `bus_clk` changes.
- R6: If the start address is odd, the first data edge carries `bus_mask`=1 with `bus_dq`=0x00. Every masked edge drives 0x00.
- R7: If the final byte address (start+count-1) is even, the last data edge carries `bus_mask`=1.
- R8: All other data edges carry `bus_mask`=0 and the stream bytes in arrival order.
- R9: The data phase has (count + odd start + even end) edges. `bus_sel_n` rises one cycle after the final data edge, with `bus_clk` low.
- R10: `busy` is high from the cycle after acceptance until the cycle in which `bus_sel_n` rises, and low from that cycle on.
- R11: While a data byte is needed and `dat_valid` is low, clock and data hold. Masked edges take no stream byte, so the stream delivers exactly count bytes.
- R12: `bus_mask_en` is low through the header and gap, and high on every data edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Burst request present |
| req_ready | output | 1 | High when idle and able to take a request |
| req_addr | input | ADDR_W | Byte start address |
| req_len | input | LEN_W | Byte count minus one |
| dat_valid | input | 1 | Stream byte present |
| dat_ready | output | 1 | Stream byte taken at this clock edge when valid |
| dat_byte | input | 8 | Stream byte |
| busy | output | 1 | Transaction in progress |
| bus_sel_n | output | 1 | Memory select, active low |
| bus_clk | output | 1 | Memory bus clock |
| bus_dq | output | 8 | Memory data bus |
| bus_mask | output | 1 | Per-edge write mask, high masks the byte |
| bus_mask_en | output | 1 | Drive enable for the mask line |

## Verification
All outputs are registered. Select and the first header byte therefore appear one cycle after the accepting edge. Header or gap edge g appears 2g+1 cycles after that, and the select release comes one cycle after the last data edge.

The bench samples on falling clock edges and counts cycles from the first sample after acceptance. It records each observed clock toggle together with the data and mask values present at it. It then compares the edge count, the edge timing and the edge contents with values it computes from the address and the count.

Under stalls only the edge contents and the lengthened duration are checked, because the edge times then depend on the source.

// File: rtl/hbw_pkg.sv
package hbw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_GAP,
        ST_DATA,
        ST_DONE
    } hbw_state_t;

    localparam int CA_BYTES = 6;

    // 48-bit write header: write, memory space, linear burst.
    function automatic logic [47:0] build_ca(input logic [31:0] wa);
        logic [47:0] c;
        c        = '0;
        c[47]    = 1'b0;
        c[46]    = 1'b0;
        c[45]    = 1'b1;
        c[44:16] = wa[31:3];
        c[2:0]   = wa[2:0];
        return c;
    endfunction

endpackage

// File: rtl/hbw_ca_gen.sv
module hbw_ca_gen #(
    parameter int WA_W  = 23,
    parameter int SEL_W = 13
) (
    input  logic [WA_W-1:0]  word_addr,
    input  logic [SEL_W-1:0] sel,
    output logic [7:0]       ca_byte
);
    logic [47:0] ca;
    logic [7:0]  ca_bytes [hbw_pkg::CA_BYTES];

    assign ca = hbw_pkg::build_ca(32'(word_addr));

    for (genvar gi = 0; gi < hbw_pkg::CA_BYTES; gi++) begin : g_byte
        assign ca_bytes[gi] = ca[47-8*gi -: 8];
    end

    always_comb begin
        ca_byte = 8'h00;
        for (int i = 0; i < hbw_pkg::CA_BYTES; i++) begin
            if (sel == SEL_W'(i)) ca_byte = ca_bytes[i];
        end
    end
endmodule

// File: rtl/hbw_edge_plan.sv
module hbw_edge_plan #(
    parameter int LEN_W = 11,
    parameter int CNT_W = 13
) (
    input  logic             start_odd,
    input  logic [LEN_W-1:0] len_m1,
    input  logic [CNT_W-1:0] idx,
    output logic [CNT_W-1:0] last_idx,
    output logic             masked
);
    logic end_even;

    // last byte address parity = start parity xor (count-1) parity
    assign end_even = ~(start_odd ^ len_m1[0]);
    assign last_idx = CNT_W'(len_m1) + CNT_W'(start_odd) + CNT_W'(end_even);
    assign masked   = ((idx == '0) && start_odd) || ((idx == last_idx) && end_even);
endmodule

// File: rtl/hbw_edge_counter.sv
module hbw_edge_counter #(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             inc,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] cnt,
    output logic             at_limit
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt <= '0;
        else if (clear) cnt <= '0;
        else if (inc)   cnt <= cnt + 1'b1;
    end

    assign at_limit = (cnt == limit);

    // R9: a phase never runs past its last edge
    a_r9_count_within_phase: assert property (@(posedge clk) disable iff (!rst_n)
        inc |-> (cnt < limit));
endmodule

// File: rtl/hbus_mask_writer.sv
module hbus_mask_writer
    import hbw_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter int LEN_W       = 11,
    parameter int LAT_PERIODS = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              dat_valid,
    output logic              dat_ready,
    input  logic [7:0]        dat_byte,
    output logic              busy,
    output logic              bus_sel_n,
    output logic              bus_clk,
    output logic [7:0]        bus_dq,
    output logic              bus_mask,
    output logic              bus_mask_en
);
    localparam int WA_W      = ADDR_W - 1;
    localparam int GAP_EDGES = 2 * LAT_PERIODS;
    localparam int GAP_W     = $clog2(GAP_EDGES + 1);
    localparam int CNT_W     = (GAP_W > LEN_W + 2) ? GAP_W : LEN_W + 2;

    hbw_state_t       state_q, state_d;
    logic             ph_q, ph_d;
    logic [WA_W-1:0]  lat_waddr;
    logic             lat_odd;
    logic [LEN_W-1:0] lat_len;

    logic [CNT_W-1:0] cnt, limit, last_idx;
    logic             at_limit, masked_now;
    logic [7:0]       ca_byte;
    logic [WA_W-1:0]  ca_waddr;
    logic [CNT_W-1:0] ca_sel;
    logic             in_bus, strobe, setup_go, cnt_clear, cnt_inc;

    assign in_bus    = (state_q == ST_CMD) || (state_q == ST_GAP) || (state_q == ST_DATA);
    assign strobe    = in_bus && ph_q;
    assign setup_go  = in_bus && !ph_q &&
                       ((state_q != ST_DATA) || masked_now || dat_valid);
    assign cnt_clear = ((state_q == ST_IDLE) && req_valid) || (strobe && at_limit);
    assign cnt_inc   = strobe && !at_limit;

    assign req_ready = (state_q == ST_IDLE);
    assign busy      = (state_q != ST_IDLE);
    assign dat_ready = (state_q == ST_DATA) && !ph_q && !masked_now;

    assign ca_waddr  = (state_q == ST_IDLE) ? req_addr[ADDR_W-1:1] : lat_waddr;
    assign ca_sel    = (state_q == ST_IDLE) ? '0 : cnt;

    always_comb begin
        unique case (state_q)
            ST_CMD:  limit = CNT_W'(CA_BYTES - 1);
            ST_GAP:  limit = CNT_W'(GAP_EDGES - 1);
            ST_DATA: limit = last_idx;
            default: limit = '0;
        endcase
    end

    hbw_ca_gen #(.WA_W(WA_W), .SEL_W(CNT_W)) u_ca (
        .word_addr (ca_waddr),
        .sel       (ca_sel),
        .ca_byte   (ca_byte)
    );

    hbw_edge_plan #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_plan (
        .start_odd (lat_odd),
        .len_m1    (lat_len),
        .idx       (cnt),
        .last_idx  (last_idx),
        .masked    (masked_now)
    );

    hbw_edge_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (cnt_clear),
        .inc      (cnt_inc),
        .limit    (limit),
        .cnt      (cnt),
        .at_limit (at_limit)
    );

    // next state
    always_comb begin
        state_d = state_q;
        ph_d    = ph_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    state_d = ST_CMD;
                    ph_d    = 1'b1;
                end
            end
            ST_CMD, ST_GAP, ST_DATA: begin
                if (ph_q) begin
                    ph_d = 1'b0;
                    if (at_limit) begin
                        if (state_q == ST_CMD)      state_d = ST_GAP;
                        else if (state_q == ST_GAP) state_d = ST_DATA;
                        else                        state_d = ST_DONE;
                    end
                end else if (setup_go) begin
                    ph_d = 1'b1;
                end
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ph_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            ph_q    <= ph_d;
        end
    end

    // registered outputs and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_sel_n   <= 1'b1;
            bus_clk     <= 1'b0;
            bus_dq      <= 8'h00;
            bus_mask    <= 1'b0;
            bus_mask_en <= 1'b0;
            lat_waddr   <= '0;
            lat_odd     <= 1'b0;
            lat_len     <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        bus_sel_n <= 1'b0;
                        bus_dq    <= ca_byte;
                        lat_waddr <= req_addr[ADDR_W-1:1];
                        lat_odd   <= req_addr[0];
                        lat_len   <= req_len;
                    end
                end
                ST_CMD, ST_GAP, ST_DATA: begin
                    if (ph_q) begin
                        bus_clk <= ~bus_clk;
                    end else if (setup_go) begin
                        if (state_q == ST_CMD) begin
                            bus_dq <= ca_byte;
                        end else if (state_q == ST_GAP) begin
                            bus_dq <= 8'h00;
                        end else begin
                            bus_dq      <= masked_now ? 8'h00 : dat_byte;
                            bus_mask    <= masked_now;
                            bus_mask_en <= 1'b1;
                        end
                    end
                end
                ST_DONE: begin
                    bus_sel_n   <= 1'b1;
                    bus_dq      <= 8'h00;
                    bus_mask    <= 1'b0;
                    bus_mask_en <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    // R2: clock parked low while deselected
    a_r2_clk_low_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel_n |-> !bus_clk);

    // R2: select leads the first rising edge by one cycle
    a_r2_select_then_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_sel_n) |=> bus_clk);

    // R5: data never moves together with the clock
    a_r5_data_stable_at_edge: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bus_clk) |-> $stable(bus_dq));

    // R10: busy covers the whole selected window
    a_r10_busy_while_selected: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel_n |-> busy);

    // R1: a transaction starts only from an accepted request
    a_r1_start_from_accept: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid && req_ready));

    // R8: interior data edges are never masked
    a_r8_interior_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA && ph_q && cnt != '0 && !at_limit) |-> !bus_mask);

    // R12: mask line driven only around the data phase
    a_r12_mask_drive_window: assert property (@(posedge clk) disable iff (!rst_n)
        bus_mask_en |-> (state_q == ST_DATA || state_q == ST_DONE));

    // R11: a starved data slot freezes the bus
    a_r11_stall_holds_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA && !ph_q && !masked_now && !dat_valid)
        |=> ($stable(bus_clk) && $stable(bus_dq)));
endmodule

// File: tb/hbus_mask_writer_test.sv
module hbus_mask_writer_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW  = 8;
    localparam int LW  = 4;
    localparam int LAT = 2;
    localparam int HDR = 6;
    localparam int PRE = HDR + 2 * LAT;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [LW-1:0] req_len = '0;
    logic          dat_valid = 1'b0;
    logic          dat_ready;
    logic [7:0]    dat_byte = 8'h00;
    logic          busy, bus_sel_n, bus_clk, bus_mask, bus_mask_en;
    logic [7:0]    bus_dq;

    int checks = 0;
    int failures = 0;

    logic [7:0] e_dq   [64];
    bit         e_mask [64];
    bit         e_en   [64];
    int         e_cyc  [64];
    int         n_edges;
    int         c_end;

    always #(CLK_PERIOD/2) clk = ~clk;

    hbus_mask_writer #(.ADDR_W(AW), .LEN_W(LW), .LAT_PERIODS(LAT)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_len(req_len),
        .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_byte(dat_byte),
        .busy(busy),
        .bus_sel_n(bus_sel_n), .bus_clk(bus_clk), .bus_dq(bus_dq),
        .bus_mask(bus_mask), .bus_mask_en(bus_mask_en)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    function automatic logic [7:0] pat(input int i, input int a);
        return 8'((i * 37 + a * 5 + 3) & 255);
    endfunction

    function automatic logic [7:0] ca_exp(input int a, input int g);
        longint w, ca;
        w  = longint'(a) >> 1;
        ca = (64'd1 << 45) | ((w >> 3) << 16) | (w & 7);
        return 8'((ca >> (8 * (5 - g))) & 255);
    endfunction

    task automatic source(input int a, input int n, input bit stall);
        int i = 0;
        int t = 0;
        while (i < n) begin
            @(negedge clk);
            t++;
            if (stall && (t % 3 == 1)) begin
                dat_valid = 1'b0;
            end else begin
                dat_valid = 1'b1;
                dat_byte  = pat(i, a);
                if (dat_ready) i++;
            end
        end
        @(negedge clk);
        dat_valid = 1'b0;
    endtask

    task automatic monitor(input int a, input int l, input bit interfere);
        int  c = 0;
        int  r5bad = 0;
        int  busybad = 0;
        int  readybad = 0;
        logic pclk;
        logic [7:0] pdq;
        @(negedge clk);
        if (interfere) begin
            req_addr = AW'(a ^ 8'h5A);
            req_len  = LW'(~l);
        end else begin
            req_valid = 1'b0;
        end
        check(busy == 1'b1, "R10 busy after accept", busy, 1);
        check(bus_sel_n == 1'b0 && bus_clk == 1'b0, "R2 select low, clock low", {bus_sel_n, bus_clk}, 0);
        check(req_ready == 1'b0, "R1 ready low while busy", req_ready, 0);
        pclk = bus_clk;
        pdq  = bus_dq;
        n_edges = 0;
        while (1) begin
            @(negedge clk);
            c++;
            if (bus_sel_n) break;
            if (bus_clk != pclk) begin
                if (n_edges < 64) begin
                    e_dq[n_edges]   = bus_dq;
                    e_mask[n_edges] = bus_mask;
                    e_en[n_edges]   = bus_mask_en;
                    e_cyc[n_edges]  = c;
                end
                n_edges++;
                if (bus_dq != pdq) r5bad++;
            end
            if (!busy) busybad++;
            if (req_ready) readybad++;
            pclk = bus_clk;
            pdq  = bus_dq;
        end
        req_valid = 1'b0;
        c_end = c;
        check(r5bad == 0, "R5 data changed with clock", r5bad, 0);
        check(busybad == 0, "R10 busy dropped early", busybad, 0);
        check(readybad == 0, "R1 ready while busy", readybad, 0);
        check(busy == 1'b0, "R10 busy low at release", busy, 0);
        check(bus_clk == 1'b0, "R9 clock low at release", bus_clk, 0);
    endtask

    task automatic do_burst(input int a, input int l, input bit stall, input bit interfere);
        int  n, so, ee, e, tot, bad, firstbad_act, firstbad_exp;
        n   = l + 1;
        so  = a & 1;
        ee  = (((a + l) & 1) == 0) ? 1 : 0;
        e   = n + so + ee;
        tot = PRE + e;
        @(negedge clk);
        check(req_ready == 1'b1 && bus_sel_n == 1'b1, "R1 idle ready before request", {req_ready, bus_sel_n}, 3);
        req_valid = 1'b1;
        req_addr  = AW'(a);
        req_len   = LW'(l);
        fork
            source(a, n, stall);
            monitor(a, l, interfere);
        join
        check(n_edges == tot, "R9 total edge count", n_edges, tot);
        if (n_edges != tot || tot > 64) return;
        check(c_end == e_cyc[tot-1] + 1, "R9 release one cycle after final edge", c_end, e_cyc[tot-1] + 1);
        // R3 header bytes
        bad = 0;
        firstbad_act = 0;
        firstbad_exp = 0;
        for (int g = 0; g < HDR; g++) begin
            if (e_dq[g] != ca_exp(a, g) && bad == 0) begin
                firstbad_act = e_dq[g];
                firstbad_exp = ca_exp(a, g);
            end
            if (e_dq[g] != ca_exp(a, g)) bad++;
        end
        check(bad == 0, "R3 header byte", firstbad_act, firstbad_exp);
        // R5/R4 edge timing before data
        bad = 0;
        for (int g = 0; g < PRE; g++) if (e_cyc[g] != 2 * g + 1) bad++;
        check(bad == 0, "R5 edge timing in header and gap", bad, 0);
        check(e_cyc[PRE] > e_cyc[PRE-1], "R4 data follows gap", e_cyc[PRE], e_cyc[PRE-1]);
        if (!stall) begin
            check(e_cyc[PRE] == 2 * PRE + 1, "R4 first data edge after gap", e_cyc[PRE], 2 * PRE + 1);
            check(c_end == 2 * tot, "R9 transaction length", c_end, 2 * tot);
        end else begin
            check(c_end > 2 * tot, "R11 stall lengthens transaction", c_end, 2 * tot);
        end
        // R12 mask drive window
        bad = 0;
        for (int g = 0; g < tot; g++) if (e_en[g] != (g >= PRE)) bad++;
        check(bad == 0, "R12 mask enable window", bad, 0);
        // R6 / R7 end masks
        check(e_mask[PRE] == so[0] && (!so[0] || e_dq[PRE] == 8'h00),
              "R6 first data edge mask", {e_mask[PRE], e_dq[PRE]}, {so[0], 8'h00});
        check(e_mask[tot-1] == ee[0] && (!ee[0] || e_dq[tot-1] == 8'h00),
              "R7 last data edge mask", {e_mask[tot-1], e_dq[tot-1]}, {ee[0], 8'h00});
        // R8 / R11 interior bytes in order
        bad = 0;
        firstbad_act = 0;
        firstbad_exp = 0;
        for (int k = 0; k < e; k++) begin
            bit mexp;
            logic [7:0] dexp;
            mexp = (k == 0 && so == 1) || (k == e - 1 && ee == 1);
            dexp = mexp ? 8'h00 : pat(k - so, a);
            if ((e_mask[PRE+k] != mexp || e_dq[PRE+k] != dexp) && bad == 0) begin
                firstbad_act = {e_mask[PRE+k], e_dq[PRE+k]};
                firstbad_exp = {mexp, dexp};
            end
            if (e_mask[PRE+k] != mexp || e_dq[PRE+k] != dexp) bad++;
        end
        check(bad == 0, stall ? "R11 data under stall" : "R8 data edges in order", firstbad_act, firstbad_exp);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        failures++;
        $display("FAIL R9 watchdog: transaction never completed");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(bus_sel_n == 1'b1 && bus_clk == 1'b0 && busy == 1'b0 && bus_mask_en == 1'b0,
              "R2 reset outputs", {bus_sel_n, bus_clk, busy, bus_mask_en}, 4'b1000);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(req_ready == 1'b1 && bus_sel_n == 1'b1 && bus_clk == 1'b0,
              "R1 idle after reset", {req_ready, bus_sel_n, bus_clk}, 3'b110);
        for (int a = 0; a < 6; a++) begin
            for (int l = 0; l < 10; l++) begin
                do_burst(a, l, 1'b0, 1'b0);
            end
        end
        do_burst(255, 15, 1'b0, 1'b0);
        do_burst(254, 15, 1'b0, 1'b0);
        do_burst(3, 6, 1'b1, 1'b0);
        do_burst(4, 9, 1'b1, 1'b0);
        do_burst(1, 4, 1'b0, 1'b1);
        do_burst(2, 2, 1'b1, 1'b1);
        repeat (4) @(negedge clk);
        check(bus_sel_n == 1'b1 && busy == 1'b0, "R1 idle after interfering requests", {bus_sel_n, busy}, 2'b10);
        finish_run();
    end
endmodule